// File: doc/BRIEF.md
# I2C Open-Drain Byte Engine

This block is the bit-level engine of an I2C bus master. It turns single commands into waveforms on the two bus wires: a start condition, a stop condition, the transmission of one byte followed by the acknowledge slot, or the reception of one byte followed by the master's own acknowledge or not-acknowledge. Both wires are open-drain. The block drives each one with a pull request that either pulls the wire low or releases it. It reads back the data wire through a separate input.

Every change on the wires is followed by the same pause. The pause length is a cycle count taken from an input when a command is accepted. A controller above this block sequences the commands. For example, it sends a start, writes the address bytes, sends a start again while the clock wire is still low (a repeated start), and then reads bytes, flagging the final one. The engine accepts a new command only while it is idle. It pulses `done` when the command completes, and then returns the acknowledge result of a write or the byte of a read.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset `scl_pull` and `sda_pull` are 0 (both wires released), `cmd_ready` is 1 and `done` is 0.
- R2: A START (`cmd_op` = 0) runs four steps: release SDA with SCL left as it was, release SCL, pull SDA, pull SCL. When it is issued while SCL is pulled, it gives a repeated start.
- R3: A STOP (`cmd_op` = 1) runs three steps: pull both wires, release SCL, release SDA.
- R4: A WRITE (`cmd_op` = 2) sends `cmd_wdata` most significant bit first. Each bit is one step with SCL pulled and SDA pulled for a 0 or released for a 1, then one step with SCL released and SDA unchanged.
- R5: After the 8 data bits of a WRITE, SDA is released for a ninth clock. SDA is sampled when the SCL-high step ends, and `ack_ok` becomes 1 for a low level and 0 for a high level. A final step then holds SCL pulled.
- R6: A READ (`cmd_op` = 3) releases SDA for 8 clocks. It samples SDA when each SCL-high step ends and shifts the sample in at the least significant bit. The first sample ends up in bit 7 of `rx_data`, which is updated when `done` pulses.
- R7: In the ninth clock of a READ, SDA is pulled (acknowledge) when `cmd_last` is 0 and released when `cmd_last` is 1. SCL is then pulled for one step and SDA is released for one more step.
- R8: Each step holds the pull outputs for exactly `pause_len` clock cycles. A `pause_len` of 0 acts as 1. The value is captured when the command is accepted, so changing it during a command has no effect.
- R9: A command is accepted on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is 0 while the command runs, and `cmd_valid` is ignored during that time. In the cycle after the last step ends, `done` is 1 for one cycle and `cmd_ready` is 1 again.
- R10: Outside START and STOP, SDA changes only while SCL is pulled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pause_len | input | CNT_W | Cycles per step, captured when a command is accepted |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine is idle and can accept a command |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_last | input | 1 | READ only: 1 sends not-acknowledge |
| cmd_wdata | input | 8 | WRITE only: byte to send |
| done | output | 1 | One-cycle pulse when a command completes |
| ack_ok | output | 1 | Result of the last WRITE: 1 if the slave acknowledged |
| rx_data | output | 8 | Byte received by the last READ |
| sda_in | input | 1 | Level of the SDA wire |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions check on every cycle that SDA moves under a released SCL only as the falling edge of a start or the rising edge of a stop, and that `done` is a single-cycle pulse that arrives with `cmd_ready`. They also check that an accepted command drops `cmd_ready` at once. Only the bench's scenarios can show the exact step order and the per-step length for several pause values, including 0 and a value changed in the middle of a command. The same holds for the bit order of a written byte, the sampling point for acknowledge and read bits, and the choice between acknowledge and not-acknowledge on the final read.

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] pause_len,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_last,
  input  logic [7:0]       cmd_wdata,
  output logic             done,
  output logic             ack_ok,
  output logic [7:0]       rx_data,
  input  logic             sda_in,
  output logic             scl_pull,
  output logic             sda_pull
);

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_STOP  = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;
  localparam logic [1:0] OP_READ  = 2'd3;
  localparam logic [3:0] ACK_SLOT = 4'd8;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_STOP, S_LO, S_HI, S_TAIL, S_REL
  } st_t;

  st_t              st;
  logic [1:0]       sub;
  logic [3:0]       bitn;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] pause_q;
  logic [1:0]       op_q;
  logic             last_q;
  logic [7:0]       shreg;
  logic             tick;
  logic             is_read;

  assign cmd_ready = (st == S_IDLE);
  assign is_read   = (op_q == OP_READ);
  assign tick      = ({1'b0, cnt} + 1'b1) >= {1'b0, pause_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sub      <= '0;
      bitn     <= '0;
      cnt      <= '0;
      pause_q  <= '0;
      op_q     <= OP_START;
      last_q   <= 1'b0;
      shreg    <= '0;
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
      done     <= 1'b0;
      ack_ok   <= 1'b0;
      rx_data  <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (cmd_valid) begin
          op_q    <= cmd_op;
          last_q  <= cmd_last;
          shreg   <= cmd_wdata;
          pause_q <= pause_len;
          cnt     <= '0;
          sub     <= '0;
          bitn    <= '0;
          case (cmd_op)
            OP_START: begin
              st       <= S_START;
              sda_pull <= 1'b0;
            end
            OP_STOP: begin
              st       <= S_STOP;
              scl_pull <= 1'b1;
              sda_pull <= 1'b1;
            end
            OP_WRITE: begin
              st       <= S_LO;
              scl_pull <= 1'b1;
              sda_pull <= ~cmd_wdata[7];
            end
            default: begin
              st       <= S_LO;
              scl_pull <= 1'b1;
              sda_pull <= 1'b0;
            end
          endcase
        end
      end else if (!tick) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          S_START: begin
            sub <= sub + 1'b1;
            case (sub)
              2'd0: scl_pull <= 1'b0;
              2'd1: sda_pull <= 1'b1;
              2'd2: scl_pull <= 1'b1;
              default: begin
                st   <= S_IDLE;
                done <= 1'b1;
              end
            endcase
          end
          S_STOP: begin
            sub <= sub + 1'b1;
            case (sub)
              2'd0: scl_pull <= 1'b0;
              2'd1: sda_pull <= 1'b0;
              default: begin
                st   <= S_IDLE;
                done <= 1'b1;
              end
            endcase
          end
          S_LO: begin
            st       <= S_HI;
            scl_pull <= 1'b0;
          end
          S_HI: begin
            scl_pull <= 1'b1;
            if (bitn == ACK_SLOT) begin
              st <= S_TAIL;
              if (!is_read) ack_ok <= ~sda_in;
            end else begin
              st    <= S_LO;
              bitn  <= bitn + 1'b1;
              shreg <= {shreg[6:0], sda_in};
              if (bitn == ACK_SLOT - 4'd1)
                sda_pull <= is_read ? ~last_q : 1'b0;
              else
                sda_pull <= is_read ? 1'b0 : ~shreg[6];
            end
          end
          S_TAIL: begin
            if (is_read) begin
              st       <= S_REL;
              sda_pull <= 1'b0;
            end else begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end
          default: begin
            st      <= S_IDLE;
            done    <= 1'b1;
            rx_data <= shreg;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       done,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic [1:0] kind
);

  p_start_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull && $past(!scl_pull) && $rose(sda_pull)) |-> (kind == 2'd0));

  p_stop_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull && $past(!scl_pull) && $fell(sda_pull)) |-> (kind == 2'd1));

  p_sda_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull && $past(!scl_pull) && kind[1]) |-> $stable(sda_pull));

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .done(done), .scl_pull(scl_pull), .sda_pull(sda_pull), .kind(op_q)
);

// File: tb/i2c_byte_engine_bench.sv
module i2c_byte_engine_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] pause_len = 16'd3;
  logic        cmd_valid = 0;
  logic [1:0]  cmd_op = 0;
  logic        cmd_last = 0;
  logic [7:0]  cmd_wdata = 0;
  logic        slave_pull = 0;
  logic        cmd_ready, done, ack_ok, scl_pull, sda_pull, sda_in;
  logic [7:0]  rx_data;

  int n_chk = 0, n_fail = 0, pl = 1;
  bit exp_scl = 0, exp_sda = 0, poke = 0, finished = 0;
  string tag = "R1";

  always #2 clk = ~clk;
  assign sda_in = ~(sda_pull | slave_pull);

  i2c_byte_engine u_i2c_byte_engine (
    .clk(clk), .rst_n(rst_n), .pause_len(pause_len), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_last(cmd_last),
    .cmd_wdata(cmd_wdata), .done(done), .ack_ok(ack_ok), .rx_data(rx_data),
    .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic lines(input bit rdy, input bit dn);
    int act, exp;
    act = {scl_pull, sda_pull, cmd_ready, done};
    exp = {exp_scl, exp_sda, rdy, dn};
    chk(act == exp, tag, act, exp);
  endtask

  task automatic step(input bit s, input bit d);
    exp_scl = s; exp_sda = d;
    repeat (pl) begin
      lines(1'b0, 1'b0);
      @(negedge clk);
    end
    if (poke) begin cmd_valid = 0; poke = 0; end
  endtask

  task automatic issue(input logic [1:0] op, input bit last, input logic [7:0] wd,
                       input int p, input bit keep_valid);
    cmd_op = op; cmd_last = last; cmd_wdata = wd; pause_len = p[15:0];
    cmd_valid = 1;
    pl = (p == 0) ? 1 : p;
    @(negedge clk);
    pause_len = 16'(p + 5);
    if (keep_valid) begin poke = 1; cmd_op = 2'd1; end
    else cmd_valid = 0;
  endtask

  task automatic finish_cmd();
    lines(1'b1, 1'b1);
    @(negedge clk);
    lines(1'b1, 1'b0);
  endtask

  task automatic do_start(input int p, input bit keep_valid);
    tag = "R2";
    issue(2'd0, 0, 8'h00, p, keep_valid);
    step(exp_scl, 0); step(0, 0); step(0, 1); step(1, 1);
    finish_cmd();
  endtask

  task automatic do_stop(input int p);
    tag = "R3";
    issue(2'd1, 0, 8'h00, p, 0);
    step(1, 1); step(0, 1); step(0, 0);
    finish_cmd();
  endtask

  task automatic do_write(input logic [7:0] b, input bit slave_ack, input int p);
    tag = "R4";
    issue(2'd2, 0, b, p, 0);
    for (int i = 7; i >= 0; i--) begin
      step(1, ~b[i]); step(0, ~b[i]);
    end
    tag = "R5";
    slave_pull = slave_ack;
    step(1, 0); step(0, 0);
    slave_pull = 0;
    step(1, 0);
    finish_cmd();
    chk(ack_ok == slave_ack, "R5 ack_ok", ack_ok, slave_ack);
  endtask

  task automatic do_read(input logic [7:0] b, input bit last, input int p);
    tag = "R6";
    issue(2'd3, last, 8'h00, p, 0);
    for (int i = 7; i >= 0; i--) begin
      slave_pull = ~b[i];
      step(1, 0); step(0, 0);
    end
    slave_pull = 0;
    tag = "R7";
    step(1, ~last); step(0, ~last); step(1, ~last); step(1, 0);
    finish_cmd();
    chk(rx_data == b, "R6 rx_data", rx_data, b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    exp_scl = 0; exp_sda = 0;
    lines(1'b1, 1'b0);
    chk(ack_ok == 0 && rx_data == 0, "R1 outputs", {ack_ok, rx_data}, 0);
    rst_n = 1;
    @(negedge clk);
    lines(1'b1, 1'b0);

    do_start(3, 1);            // R9: valid held while busy is ignored
    do_write(8'hA5, 1, 3);
    do_write(8'h3C, 0, 2);
    chk(ack_ok == 0, "R5 nack", ack_ok, 0);
    do_start(1, 0);            // R2 repeated start from SCL pulled
    do_read(8'h96, 0, 2);
    do_read(8'h5B, 1, 0);      // R8 pause 0 acts as 1
    do_stop(4);
    tag = "R9";
    repeat (3) begin lines(1'b1, 1'b0); @(negedge clk); end
    do_start(2, 0);
    do_write(8'hFF, 1, 1);
    do_write(8'h00, 1, 3);
    do_read(8'h01, 1, 1);
    do_stop(1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule